// File: doc/BRIEF.md
# Frame-Rate Delay and Sound Timers

This block keeps two 8-bit countdown timers and a free-running seed counter for an interpreter-style system. All three are advanced by a single-cycle frame tick that arrives once per display frame (nominally 60 times per second). One timer serves as a general-purpose delay. The other is a sound timer whose non-zero state drives a tone-enable output.

On every tick the delay timer steps down by one unless it already reads zero, and the seed counter steps up by one. On the same tick the tone output is set or cleared from the sound timer's value as it stood before that tick. If the sound timer was non-zero, it then steps down by one. As a result, a sound timer loaded with N keeps the tone on for exactly N ticks.

A host loads either timer through a one-cycle write strobe with a select bit. All three counts are visible on read ports at all times. A host load always beats a same-cycle decrement of the timer it targets. Turning the tone-enable output into an audio waveform is left to the surrounding logic.

Top module: `frame_timers`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both timers and the seed read zero and the tone output is low.
- R2: A frame tick decrements a non-zero delay timer by exactly one, visible on the cycle after the tick.
- R3: A frame tick leaves a delay timer that reads zero at zero. It never wraps to 255.
- R4: A frame tick that sees a non-zero sound timer sets the tone output high and decrements the sound timer by one on the next cycle.
- R5: A frame tick that sees a zero sound timer drives the tone output low and leaves the sound timer at zero.
- R6: Each frame tick increments the seed by one, modulo 256 (255 is followed by 0).
- R7: On cycles with no tick and no host write, both timers, the seed and the tone output keep their values.
- R8: A host write with select 0 loads the delay timer, and one with select 1 loads the sound timer. The loaded value appears on the next cycle and the other timer is unchanged.
- R9: A host write coinciding with a tick stores the written value in the selected timer, with no decrement applied. The other timer and the seed still follow the tick, and the tone is still set from the sound timer's value before the write.
- R10: After the sound timer is loaded with N, the tone output is high for exactly N of the following ticks and low after the next one.
- R11: Stepping one timer never changes the other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle pulse per display frame |
| hostWrEn | input | 1 | Host load strobe |
| hostWrSel | input | 1 | Load target: 0 delay timer, 1 sound timer |
| hostWrData | input | 8 | Value to load |
| delayVal | output | 8 | Current delay timer |
| soundVal | output | 8 | Current sound timer |
| seedVal | output | 8 | Current seed counter |
| toneOn | output | 1 | Tone enable |

## Verification
Every piece of state in this block is exposed directly on a port, so any wrong internal value shows up on the cycle after the faulty update. Out-of-order decrement and tone logic shows up as a tone that runs one tick too long or too short. A borrow that leaks into the wrong timer shows up in the neighbouring count after a single tick. A write that loses to the decrement shows up as a loaded value one below what was written. The directed scenarios therefore read all outputs right after each tick, collision or load.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  localparam int TIMER_W = 8;
  localparam int SEED_W  = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic delayLoad;
    logic delayDec;
    logic soundLoad;
    logic soundDec;
    logic toneSet;
    logic toneClr;
    logic seedInc;
  } tmrStrobes_t;
endpackage

// File: rtl/ft_downcount.sv
module ft_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         isZero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)      count <= '0;
    else if (load)  count <= loadVal;
    else if (dec)   count <= count - ONE;
  end

  assign isZero = (count == '0);
endmodule

// File: rtl/ft_ctrl.sv
module ft_ctrl
  import frame_timer_pkg::*;
(
  input  logic        frameTick,
  input  logic        hostWrEn,
  input  logic        hostWrSel,
  input  logic        delayZero,
  input  logic        soundZero,
  output tmrStrobes_t strobes
);
  always_comb begin
    strobes           = '0;
    strobes.delayLoad = hostWrEn & ~hostWrSel;
    strobes.soundLoad = hostWrEn &  hostWrSel;
    // a load beats a same-cycle decrement
    strobes.delayDec  = frameTick & ~delayZero & ~strobes.delayLoad;
    strobes.soundDec  = frameTick & ~soundZero & ~strobes.soundLoad;
    // tone follows the pre-tick sound value
    strobes.toneSet   = frameTick & ~soundZero;
    strobes.toneClr   = frameTick &  soundZero;
    strobes.seedInc   = frameTick;
  end
endmodule

// File: rtl/ft_datapath.sv
module ft_datapath
  import frame_timer_pkg::*;
#(
  parameter int TW = TIMER_W,
  parameter int SW = SEED_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrStrobes_t   strobes,
  input  logic [TW-1:0] wrData,
  output logic [TW-1:0] delayVal,
  output logic [TW-1:0] soundVal,
  output logic [SW-1:0] seedVal,
  output logic          toneOn,
  output logic          delayZero,
  output logic          soundZero
);
  localparam int NUM_TMR = 2;
  localparam logic [SW-1:0] SEED_STEP = SW'(1);

  logic [NUM_TMR-1:0]         loadV, decV, zeroV;
  logic [NUM_TMR-1:0][TW-1:0] cntV;

  assign loadV = {strobes.soundLoad, strobes.delayLoad};
  assign decV  = {strobes.soundDec,  strobes.delayDec};

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    ft_downcount #(.W(TW)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .load    (loadV[i]),
      .dec     (decV[i]),
      .loadVal (wrData),
      .count   (cntV[i]),
      .isZero  (zeroV[i])
    );
  end

  assign delayVal  = cntV[0];
  assign soundVal  = cntV[1];
  assign delayZero = zeroV[0];
  assign soundZero = zeroV[1];

  always_ff @(posedge clk) begin
    if (!rstN)                seedVal <= '0;
    else if (strobes.seedInc) seedVal <= seedVal + SEED_STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                toneOn <= 1'b0;
    else if (strobes.toneSet) toneOn <= 1'b1;
    else if (strobes.toneClr) toneOn <= 1'b0;
  end

  // R11: a decrement of one timer leaves the other untouched
  p_indep_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.delayDec && !strobes.soundLoad) |=> $stable(soundVal) || $past(strobes.soundDec));
endmodule

// File: rtl/frame_timers.sv
module frame_timers
  import frame_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameTick,
  input  logic               hostWrEn,
  input  logic               hostWrSel,
  input  logic [TIMER_W-1:0] hostWrData,
  output logic [TIMER_W-1:0] delayVal,
  output logic [TIMER_W-1:0] soundVal,
  output logic [SEED_W-1:0]  seedVal,
  output logic               toneOn
);
  tmrStrobes_t strobes;
  logic        delayZero, soundZero;

  ft_ctrl u_ctrl (
    .frameTick (frameTick),
    .hostWrEn  (hostWrEn),
    .hostWrSel (hostWrSel),
    .delayZero (delayZero),
    .soundZero (soundZero),
    .strobes   (strobes)
  );

  ft_datapath #(.TW(TIMER_W), .SW(SEED_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (hostWrData),
    .delayVal  (delayVal),
    .soundVal  (soundVal),
    .seedVal   (seedVal),
    .toneOn    (toneOn),
    .delayZero (delayZero),
    .soundZero (soundZero)
  );

  logic delayWr, soundWr;
  assign delayWr = hostWrEn && !hostWrSel;
  assign soundWr = hostWrEn &&  hostWrSel;

  p_delay_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !delayWr && delayVal != '0) |=> delayVal == TIMER_W'($past(delayVal) - TIMER_W'(1)));

  p_delay_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !delayWr && delayVal == '0) |=> delayVal == '0);

  p_tone_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && soundVal != '0) |=> toneOn);

  p_tone_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && soundVal == '0) |=> !toneOn);

  p_seed_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> seedVal == SEED_W'($past(seedVal) + SEED_W'(1)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && !hostWrEn) |=> $stable(delayVal) && $stable(soundVal) && $stable(seedVal) && $stable(toneOn));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    delayWr |=> delayVal == $past(hostWrData));

  p_load_snd_r8: assert property (@(posedge clk) disable iff (!rstN)
    soundWr |=> soundVal == $past(hostWrData));
endmodule

// File: tb/frame_timers_bench.sv
module frame_timers_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0;
  logic       hostWrEn = 1'b0;
  logic       hostWrSel = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] delayVal, soundVal, seedVal;
  logic       toneOn;

  int errors = 0;
  int checks = 0;
  int tickCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_timers u_frame_timers (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .hostWrEn(hostWrEn),
    .hostWrSel(hostWrSel), .hostWrData(hostWrData), .delayVal(delayVal),
    .soundVal(soundVal), .seedVal(seedVal), .toneOn(toneOn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one active cycle of stimulus, returns at the next negedge with results settled
  task automatic step(input logic t, input logic w, input logic s, input logic [7:0] d);
    @(negedge clk);
    frameTick = t; hostWrEn = w; hostWrSel = s; hostWrData = d;
    @(negedge clk);
    frameTick = 1'b0; hostWrEn = 1'b0;
    if (t) tickCount++;
  endtask

  task automatic t_reset();
    check("R1", "delay", delayVal, 0);
    check("R1", "sound", soundVal, 0);
    check("R1", "seed", seedVal, 0);
    check("R1", "tone", toneOn, 0);
  endtask

  task automatic t_delay();
    step(0, 1, 0, 8'd3);
    check("R8", "delay loaded", delayVal, 3);
    check("R8", "sound untouched", soundVal, 0);
    for (int i = 2; i >= 0; i--) begin
      step(1, 0, 0, 8'd0);
      check("R2", "delay step", delayVal, i);
    end
    step(1, 0, 0, 8'd0);
    check("R3", "delay floor", delayVal, 0);
    check("R5", "tone low on zero sound", toneOn, 0);
  endtask

  task automatic t_sound_len();
    int highs = 0;
    step(0, 1, 1, 8'd5);
    check("R8", "sound loaded", soundVal, 5);
    check("R8", "delay untouched", delayVal, 0);
    step(1, 0, 0, 8'd0);
    check("R4", "tone set", toneOn, 1);
    check("R4", "sound step", soundVal, 4);
    highs = 1;
    for (int i = 0; i < 7; i++) begin
      step(1, 0, 0, 8'd0);
      if (toneOn) highs++;
    end
    check("R10", "tone ticks", highs, 5);
    check("R5", "tone cleared", toneOn, 0);
    check("R5", "sound stays zero", soundVal, 0);
  endtask

  task automatic t_seed();
    check("R6", "seed count", seedVal, tickCount % 256);
    for (int i = 0; i < 260; i++) step(1, 0, 0, 8'd0);
    check("R6", "seed wrap", seedVal, tickCount % 256);
  endtask

  task automatic t_idle();
    step(0, 1, 0, 8'd9);
    step(0, 1, 1, 8'd6);
    step(1, 0, 0, 8'd0);
    for (int i = 0; i < 10; i++) @(negedge clk);
    check("R7", "delay hold", delayVal, 8);
    check("R7", "sound hold", soundVal, 5);
    check("R7", "tone hold", toneOn, 1);
    check("R7", "seed hold", seedVal, tickCount % 256);
  endtask

  task automatic t_collide();
    step(0, 1, 0, 8'd10);
    step(0, 1, 1, 8'd4);
    step(1, 1, 0, 8'd7);
    check("R9", "delay load wins", delayVal, 7);
    check("R9", "sound still ticks", soundVal, 3);
    check("R9", "seed still ticks", seedVal, tickCount % 256);
    step(1, 1, 1, 8'd0);
    check("R9", "sound load wins", soundVal, 0);
    check("R9", "tone from pre-write", toneOn, 1);
    check("R9", "delay still ticks", delayVal, 6);
    step(1, 0, 0, 8'd0);
    check("R9", "tone drops after", toneOn, 0);
  endtask

  task automatic t_indep();
    step(0, 1, 0, 8'd0);
    step(0, 1, 1, 8'd2);
    step(1, 0, 0, 8'd0);
    check("R11", "delay unaffected by sound step", delayVal, 0);
    check("R11", "sound step", soundVal, 1);
    step(0, 1, 0, 8'd2);
    step(1, 0, 0, 8'd0);
    step(1, 0, 0, 8'd0);
    check("R11", "sound floor with delay stepping", soundVal, 0);
    check("R11", "delay stepping", delayVal, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "delay in reset", delayVal, 0);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_delay();
    t_sound_len();
    t_seed();
    t_idle();
    t_collide();
    t_indep();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule